// File: doc/BRIEF.md
# Codec Serial Control Interface

This block is the serial slave front end of a combined 8-bit analog-to-digital and digital-to-analog codec. A frame is active while the active-low chip select is held low. During a frame the block takes 8-bit control words from the serial data input on rising serial-clock edges. It loads the DAC holding register from the data byte that follows a DAC-write word. It returns the converter result on the serial output, with a separate output-enable that stands in for the high-impedance state. It also issues the conversion-start strobe for a separate converter core. That core returns its result on a parallel bus together with a done strobe.

The serial pins are sampled on the system clock, and the block finds serial-clock and chip-select edges by comparing each sample with the one before it. If chip select rises in the middle of a transfer, the recovery depends on the phase that was interrupted. A partial control word sends the block to its power-up state. A partial DAC byte is dropped. An interrupted readout goes quiet and then continues from the next unsent bit. Two further rules apply. A word that changes the input multiplexer only switches the multiplexer and starts no conversion. In the ADC-only mode, conversions restart on their own until a chip-select interruption breaks the chain.

Top module: `codec_serial_if`

## Requirements
- R1: After reset, `adc_en`, `dac_en`, `pwr_mode`, `mux_sel`, `conv_start`, `dac_load` and `dout_oe` are 0, and `dac_code` is 0.
- R2: Control words are shifted in MSB first on rising `sclk` edges while `cs_n` is low. Bit 7 is the start flag, bit 4 is DAC-write, bit 3 is the multiplexer select, bit 2 is the power mode, bit 1 is ADC enable and bit 0 is DAC enable. Bits 6 and 5 are unused. A completed word with bit 7 set copies bits 2..0 to `pwr_mode`, `adc_en` and `dac_en`. A word with bit 7 clear changes nothing.
- R3: A valid word with ADC enable 1, DAC-write 0 and a multiplexer select equal to the current `mux_sel` raises `conv_start` for exactly one clock. `conv_start` is never high while `adc_en` is 0.
- R4: A valid word whose multiplexer select differs from `mux_sel` updates `mux_sel` and raises no `conv_start`. A second word with the same select then starts a conversion.
- R5: After a valid word with DAC-write 1, the next 8 serial bits are taken MSB first into `dac_code`, and `dac_load` pulses once. This happens even when the DAC enable bit is 0.
- R6: If `cs_n` rises after 1 to 7 bits of a control word, the block returns to the R1 state: all configuration outputs 0 and `dac_code` 0.
- R7: If `cs_n` rises during the DAC data byte, the partial bits are dropped, `dac_code` keeps its value, and the bits of the next frame are read as a control word.
- R8: Once `adc_done` arrives for a started conversion, the result MSB appears on `dout` with `dout_oe` 1 whenever `cs_n` is low. Each falling `sclk` edge moves to the next lower bit. After the 8th falling edge, `dout_oe` returns to 0. Serial input is not decoded during a readout.
- R9: While `cs_n` is high during a readout, `dout_oe` is 0 and `sclk` has no effect. When `cs_n` falls again, the unsent bits continue in order.
- R10: When `adc_en` is 1 and `dac_en` is 0, the end of each readout raises `conv_start` again by itself. This stops after any chip-select interruption until a new valid word is received. A new valid word replaces the configuration.
- R11: A `sclk` edge seen in the same clock in which `cs_n` is high is ignored, so no bit is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data in |
| dout | output | 1 | Serial result bit, valid when `dout_oe` is 1 |
| dout_oe | output | 1 | Output enable for `dout`; 0 means high impedance |
| adc_data | input | DATA_W | Conversion result from the converter core |
| adc_done | input | 1 | One-clock strobe: `adc_data` is valid |
| conv_start | output | 1 | One-clock request to start a conversion |
| adc_en | output | 1 | ADC enable from the last valid word |
| dac_en | output | 1 | DAC enable from the last valid word |
| pwr_mode | output | 1 | Power-mode bit from the last valid word |
| mux_sel | output | 1 | Analog input multiplexer select |
| dac_code | output | DATA_W | DAC holding register |
| dac_load | output | 1 | One-clock pulse when `dac_code` is written |

## Verification
Two events can fall in the same clock: the rising `sclk` edge that would complete a control word, and the rising edge of `cs_n` that cuts the frame. The bench drives both pins in one clock cycle after seven bits of a word that would enable the ADC. It then expects the abort state of R6, not the configuration the completed word would have produced. A second overlap arises at the end of a readout in ADC-only mode, where the automatic restart must not collide with a later chip-select interruption. The bench judges this case by counting `conv_start` pulses across an interrupted readout.

// File: rtl/codec_pkg.sv
package codec_pkg;

  localparam int CW_W      = 8;
  localparam int START_POS = 7;
  localparam int DACWR_POS = 4;
  localparam int MUX_POS   = 3;
  localparam int PWR_POS   = 2;
  localparam int ADCEN_POS = 1;
  localparam int DACEN_POS = 0;

  typedef enum logic [1:0] {
    PH_CTRL = 2'd0,
    PH_DAC  = 2'd1,
    PH_READ = 2'd2
  } phase_e;

  typedef struct packed {
    logic start;
    logic dac_wr;
    logic mux;
    logic pwr;
    logic adc_on;
    logic dac_on;
  } ctrl_fields_t;

  function automatic ctrl_fields_t decode_ctrl(input logic [CW_W-1:0] w);
    ctrl_fields_t f;
    f.start  = w[START_POS];
    f.dac_wr = w[DACWR_POS];
    f.mux    = w[MUX_POS];
    f.pwr    = w[PWR_POS];
    f.adc_on = w[ADCEN_POS];
    f.dac_on = w[DACEN_POS];
    return f;
  endfunction

  function automatic logic word_starts_conv(input ctrl_fields_t f, input logic cur_mux);
    return f.adc_on && !f.dac_wr && (f.mux == cur_mux);
  endfunction

  function automatic logic adc_only_mode(input logic adc_on, input logic dac_on);
    return adc_on && !dac_on;
  endfunction

endpackage

// File: rtl/codec_edge_det.sv
module codec_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_rise,
  output logic cs_fall
);
  logic sclk_q;
  logic cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
    end
  end

  // Chip select high wins over any clock edge in the same cycle.
  assign sclk_rise = sclk && !sclk_q && !cs_n;
  assign sclk_fall = !sclk && sclk_q && !cs_n;
  assign cs_rise   = cs_n && !cs_q;
  assign cs_fall   = !cs_n && cs_q;
endmodule

// File: rtl/codec_shift_in.sv
module codec_shift_in #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word_next,
  output logic         last,
  output logic         partial
);
  localparam int CNT_W = $clog2(W) + 1;

  logic [W-1:0]     sr_q;
  logic [CNT_W-1:0] cnt_q;

  assign word_next = {sr_q[W-2:0], din};
  assign last      = shift_en && (cnt_q == CNT_W'(W-1));
  assign partial   = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (shift_en) sr_q <= word_next;
      if (last)          cnt_q <= '0;
      else if (clr)      cnt_q <= shift_en ? CNT_W'(1) : '0;
      else if (shift_en) cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/codec_shift_out.sv
module codec_shift_out #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         shift_en,
  output logic         bit_out,
  output logic         last
);
  localparam int CNT_W = $clog2(W) + 1;

  logic [W-1:0]     sr_q;
  logic [CNT_W-1:0] cnt_q;

  assign bit_out = sr_q[W-1];
  assign last    = shift_en && (cnt_q == CNT_W'(W-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (load) begin
      sr_q  <= load_data;
      cnt_q <= '0;
    end else if (shift_en) begin
      sr_q  <= {sr_q[W-2:0], 1'b0};
      cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/codec_serial_if.sv
module codec_serial_if
  import codec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  output logic              dout,
  output logic              dout_oe,
  input  logic [DATA_W-1:0] adc_data,
  input  logic              adc_done,
  output logic              conv_start,
  output logic              adc_en,
  output logic              dac_en,
  output logic              pwr_mode,
  output logic              mux_sel,
  output logic [DATA_W-1:0] dac_code,
  output logic              dac_load
);

  // Named events, also observed by the bound checker.
  logic sclk_rise, sclk_fall, cs_rise, cs_fall;
  logic ctrl_shift_en, ctrl_clr, ctrl_last, ctrl_partial;
  logic ctrl_word_valid, ctrl_abort;
  logic dac_shift_en, dac_last, dac_partial, dac_abort;
  logic rd_load, rd_shift_en, rd_last, rd_bit, rd_pause;
  logic [CW_W-1:0]   ctrl_word;
  logic [DATA_W-1:0] dac_word;
  ctrl_fields_t      fields;

  phase_e            phase_q;
  logic              need_ctrl_q;
  logic              busy_q;
  logic              res_valid_q;
  logic [DATA_W-1:0] res_q;
  logic              adc_en_q, dac_en_q, pwr_q, mux_q;
  logic [DATA_W-1:0] dac_q;
  logic              conv_q, dac_load_q;

  codec_edge_det edge_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_rise   (cs_rise),
    .cs_fall   (cs_fall)
  );

  assign ctrl_shift_en = sclk_rise && (phase_q == PH_CTRL);
  assign ctrl_clr      = cs_fall || rd_load;

  codec_shift_in #(.W(CW_W)) ctrl_rx_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (ctrl_clr),
    .shift_en  (ctrl_shift_en),
    .din       (din),
    .word_next (ctrl_word),
    .last      (ctrl_last),
    .partial   (ctrl_partial)
  );

  assign fields          = decode_ctrl(ctrl_word);
  assign ctrl_word_valid = ctrl_last && fields.start;
  assign ctrl_abort      = cs_rise && (phase_q == PH_CTRL) && ctrl_partial;

  assign dac_shift_en = sclk_rise && (phase_q == PH_DAC);
  assign dac_abort    = cs_rise && (phase_q == PH_DAC);

  codec_shift_in #(.W(DATA_W)) dac_rx_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cs_fall),
    .shift_en  (dac_shift_en),
    .din       (din),
    .word_next (dac_word),
    .last      (dac_last),
    .partial   (dac_partial)
  );

  assign rd_load     = res_valid_q && (phase_q == PH_CTRL) && !ctrl_partial && !ctrl_shift_en;
  assign rd_shift_en = sclk_fall && (phase_q == PH_READ);
  assign rd_pause    = cs_rise && (phase_q == PH_READ);

  codec_shift_out #(.W(DATA_W)) rd_tx_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rd_load),
    .load_data (res_q),
    .shift_en  (rd_shift_en),
    .bit_out   (rd_bit),
    .last      (rd_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_CTRL;
      need_ctrl_q <= 1'b1;
      busy_q      <= 1'b0;
      res_valid_q <= 1'b0;
      res_q       <= '0;
      adc_en_q    <= 1'b0;
      dac_en_q    <= 1'b0;
      pwr_q       <= 1'b0;
      mux_q       <= 1'b0;
      dac_q       <= '0;
      conv_q      <= 1'b0;
      dac_load_q  <= 1'b0;
    end else begin
      conv_q     <= 1'b0;
      dac_load_q <= 1'b0;

      if (adc_done && busy_q) begin
        res_q       <= adc_data;
        res_valid_q <= 1'b1;
        busy_q      <= 1'b0;
      end

      if (ctrl_abort) begin
        // Return to the power-up state: full shutdown.
        phase_q     <= PH_CTRL;
        need_ctrl_q <= 1'b1;
        busy_q      <= 1'b0;
        res_valid_q <= 1'b0;
        adc_en_q    <= 1'b0;
        dac_en_q    <= 1'b0;
        pwr_q       <= 1'b0;
        mux_q       <= 1'b0;
        dac_q       <= '0;
      end else if (dac_abort) begin
        phase_q     <= PH_CTRL;
        need_ctrl_q <= 1'b1;
      end else if (rd_pause) begin
        need_ctrl_q <= 1'b1;
      end

      if (ctrl_word_valid) begin
        need_ctrl_q <= 1'b0;
        adc_en_q    <= fields.adc_on;
        dac_en_q    <= fields.dac_on;
        pwr_q       <= fields.pwr;
        if (fields.dac_wr) phase_q <= PH_DAC;
        if (fields.mux != mux_q) begin
          mux_q <= fields.mux;
        end else if (word_starts_conv(fields, mux_q)) begin
          conv_q <= 1'b1;
          busy_q <= 1'b1;
        end
      end

      if (dac_last) begin
        dac_q      <= dac_word;
        dac_load_q <= 1'b1;
        phase_q    <= PH_CTRL;
      end

      if (rd_load) begin
        phase_q     <= PH_READ;
        res_valid_q <= 1'b0;
      end

      if (rd_last) begin
        phase_q <= PH_CTRL;
        if (adc_only_mode(adc_en_q, dac_en_q) && !need_ctrl_q) begin
          conv_q <= 1'b1;
          busy_q <= 1'b1;
        end
      end
    end
  end

  assign dout_oe    = (phase_q == PH_READ) && !cs_n;
  assign dout       = dout_oe && rd_bit;
  assign conv_start = conv_q;
  assign adc_en     = adc_en_q;
  assign dac_en     = dac_en_q;
  assign pwr_mode   = pwr_q;
  assign mux_sel    = mux_q;
  assign dac_code   = dac_q;
  assign dac_load   = dac_load_q;

endmodule

// File: rtl/codec_serial_if_chk.sv
module codec_serial_if_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              conv_start,
  input logic              adc_en,
  input logic              mux_sel,
  input logic [DATA_W-1:0] dac_code,
  input logic              dac_load,
  input logic              ctrl_abort,
  input logic              dac_abort
);

  assert_conv_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_conv_needs_adc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> adc_en);

  assert_mux_switch_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_sel != $past(mux_sel)) |-> !conv_start);

  assert_abort_shutdown_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_abort |=> (!adc_en && !mux_sel && (dac_code == '0)));

  assert_dac_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dac_abort |=> $stable(dac_code));

  assert_no_load_deselected_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> !dac_load);

endmodule

bind codec_serial_if codec_serial_if_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .conv_start (conv_start),
  .adc_en     (adc_en),
  .mux_sel    (mux_sel),
  .dac_code   (dac_code),
  .dac_load   (dac_load),
  .ctrl_abort (ctrl_abort),
  .dac_abort  (dac_abort)
);

// File: tb/codec_serial_if_tb.sv
module codec_serial_if_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int NVEC = 7;
  // {word, pwr, adc, dac, mux, conv_expected}
  localparam logic [12:0] VEC [NVEC] = '{
    {8'h83, 4'b0110, 1'b1},
    {8'h03, 4'b0110, 1'b0},
    {8'h8E, 4'b1101, 1'b0},
    {8'h8E, 4'b1101, 1'b1},
    {8'h84, 4'b1000, 1'b0},
    {8'h80, 4'b0000, 1'b0},
    {8'h87, 4'b1110, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, din, adc_done;
  logic [7:0] adc_data;
  logic dout, dout_oe, conv_start, adc_en, dac_en, pwr_mode, mux_sel, dac_load;
  logic [7:0] dac_code;
  int checks = 0, failures = 0, conv_cnt = 0, load_cnt = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_serial_if #(.DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .dout(dout), .dout_oe(dout_oe), .adc_data(adc_data), .adc_done(adc_done),
    .conv_start(conv_start), .adc_en(adc_en), .dac_en(dac_en),
    .pwr_mode(pwr_mode), .mux_sel(mux_sel), .dac_code(dac_code), .dac_load(dac_load)
  );

  always @(negedge clk) begin
    if (conv_start) conv_cnt++;
    if (dac_load) load_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; din = 1'b0;
    adc_done = 1'b0; adc_data = 8'h00;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
  endtask

  task automatic cs_low();  cs_n = 1'b0; wait_clk(HALF); endtask
  task automatic cs_high(); cs_n = 1'b1; wait_clk(HALF); endtask

  task automatic send_bit(input logic b);
    din = b;  wait_clk(HALF);
    sclk = 1'b1; wait_clk(HALF);
    sclk = 1'b0; wait_clk(HALF);
  endtask

  task automatic send_word(input logic [7:0] w);
    for (int i = 7; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic read_bits(input int n, inout logic [7:0] acc, input string req);
    for (int i = 0; i < n; i++) begin
      chk(req, dout_oe, 1'b1);
      acc = {acc[6:0], dout};
      sclk = 1'b1; wait_clk(HALF);
      sclk = 1'b0; wait_clk(HALF);
    end
  endtask

  task automatic adc_finish(input logic [7:0] v);
    adc_data = v; adc_done = 1'b1;
    wait_clk(1);
    adc_done = 1'b0;
    wait_clk(3);
  endtask

  initial begin
    logic [7:0] acc;
    int c0;
    do_reset();
    // R1 reset state
    chk("R1", {adc_en, dac_en, pwr_mode, mux_sel, conv_start, dac_load, dout_oe}, 7'b0);
    chk("R1", dac_code, 8'h00);

    // R2 R3 R4 vector walk
    for (int i = 0; i < NVEC; i++) begin
      c0 = conv_cnt;
      cs_low(); send_word(VEC[i][12:5]); cs_high();
      chk("R2", {pwr_mode, adc_en, dac_en, mux_sel}, VEC[i][4:1]);
      chk("R3", conv_cnt - c0, {31'b0, VEC[i][0]});
    end

    // R5 DAC write with DAC disabled
    do_reset();
    cs_low(); send_word(8'h90); send_word(8'hA5); cs_high();
    chk("R5", dac_code, 8'hA5);
    chk("R5", dac_en, 1'b0);
    chk("R5", load_cnt, 1);

    // R7 interrupted DAC byte, next frame is a control word
    cs_low(); send_word(8'h91);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    cs_high();
    chk("R7", dac_code, 8'hA5);
    c0 = conv_cnt;
    cs_low(); send_word(8'h83); cs_high();
    chk("R7", {adc_en, dac_en}, 2'b11);
    chk("R7", conv_cnt - c0, 1);
    chk("R7", dac_code, 8'hA5);

    // R6 partial control word
    cs_low(); send_word(8'h89); cs_high();
    chk("R6", mux_sel, 1'b1);
    cs_low(); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); cs_high();
    chk("R6", {pwr_mode, adc_en, dac_en, mux_sel}, 4'b0000);
    chk("R6", dac_code, 8'h00);

    // R8 plain readout, not ADC-only mode
    do_reset();
    cs_low(); send_word(8'h83); cs_high();
    adc_finish(8'hB4);
    chk("R8", dout_oe, 1'b0);
    c0 = conv_cnt;
    cs_low(); acc = 0; read_bits(8, acc, "R8");
    chk("R8", acc, 8'hB4);
    chk("R8", dout_oe, 1'b0);
    cs_high();
    chk("R8", conv_cnt - c0, 0);

    // R9 readout interrupted and resumed
    do_reset();
    cs_low(); send_word(8'h83); cs_high();
    adc_finish(8'h5C);
    cs_low(); acc = 0; read_bits(3, acc, "R9");
    cs_high();
    chk("R9", dout_oe, 1'b0);
    for (int i = 0; i < 2; i++) begin
      sclk = 1'b1; wait_clk(HALF); sclk = 1'b0; wait_clk(HALF);
    end
    cs_low(); read_bits(5, acc, "R9");
    cs_high();
    chk("R9", acc, 8'h5C);

    // R10 ADC-only auto restart, broken by interruption, then reconfigured
    do_reset();
    c0 = conv_cnt;
    cs_low(); send_word(8'h82); cs_high();
    adc_finish(8'h3C);
    cs_low(); acc = 0; read_bits(8, acc, "R10"); cs_high();
    chk("R10", acc, 8'h3C);
    chk("R10", conv_cnt - c0, 2);
    adc_finish(8'hC3);
    cs_low(); acc = 0; read_bits(3, acc, "R10"); cs_high();
    cs_low(); read_bits(5, acc, "R10"); cs_high();
    chk("R10", acc, 8'hC3);
    chk("R10", conv_cnt - c0, 2);
    cs_low(); send_word(8'h83); cs_high();
    chk("R10", {adc_en, dac_en}, 2'b11);
    chk("R10", conv_cnt - c0, 3);

    // R11 chip select and final clock edge in the same cycle
    do_reset();
    cs_low(); send_word(8'h87); cs_high();
    chk("R11", {pwr_mode, adc_en, dac_en}, 3'b111);
    c0 = conv_cnt;
    cs_low();
    for (int i = 7; i >= 1; i--) send_bit(8'h82 >> i);
    din = 1'b0; wait_clk(HALF);
    sclk = 1'b1; cs_n = 1'b1; wait_clk(HALF);
    sclk = 1'b0; wait_clk(HALF);
    chk("R11", {pwr_mode, adc_en, dac_en, mux_sel}, 4'b0000);
    chk("R11", conv_cnt - c0, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule